// File: doc/BRIEF.md
# Control-Word Driven Register/ALU Datapath

This block is the datapath of a small processor. It holds five parallel-load registers: an instruction register, an address register, two general data registers and a program counter. Around them sit an operand multiplexer, a 32-code ALU and a result router. The block has no sequencer. Each clock cycle one flat control word sets up the path. The word gives every register a load enable and a drive enable, and it carries the operand select, the ALU function code, the result route and a separate program-counter increment bit.

An external controller steps through control words, one for each machine state. In the first fetch state the word routes the program counter through the ALU pass-B function into the address register, which then drives the address bus. Later states increment the counter on its own path and load fetched bytes from the data-in bus into the instruction register. The instruction register is exported so the controller can decode it.

Top module: `dp_core`

## Requirements
- R1: After reset every register holds zero, so with drive enables set the address bus and the exported instruction value read zero.
- R2: Control word `ctl_i` bit map (18 bits): [17] IR load, [16] IR drive, [15] AR load, [14] AR drive, [13] D1 load, [12] D1 drive, [11] D2 load, [10] D2 drive, [9] PC load, [8] PC drive, [7] operand select, [6:2] ALU code (bit 6 is the first code bit), [1] result route, [0] PC increment.
- R3: A register with its load bit set takes a new value on the rising clock edge. IR, D1, D2 and PC take `din_i`. AR takes `din_i` zero-extended when the route bit is 0. A register whose load bit is clear holds its value.
- R4: When a register's drive bit is 0, the register contributes zero wherever it is read: ALU operand, address bus or instruction export.
- R5: The ALU A operand is D2. The ALU B operand is D1 when the operand select is 0 and PC when it is 1.
- R6: With route bit 0 the ALU result appears on `dout_o`. With route bit 1 `dout_o` is zero and the result, zero-extended, is what AR loads when its load bit is set.
- R7: ALU codes: 00000 A+B, 00001 A-B, 00010 A+1, 00011 A-1, 00100 pass A, 00101 pass B, 10000 AND, 10001 OR, 10010 XOR, 10011 NOT A. Every other code yields zero.
- R8: `carry_o` is the carry out of code 00000 and is 0 for every other code.
- R9: The fetch word 18'b00_11_00_00_01_1_00101_1_0 places the PC value on `addr_o` after one clock edge.
- R10: The increment bit adds one to PC modulo 256 on a clock edge without using the ALU. If the PC load bit is also set, the load wins.
- R11: `ir_o` shows IR when the IR drive bit is set and zero otherwise. `addr_o` shows AR when the AR drive bit is set and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_i | input | 18 | Control word for the current state |
| din_i | input | 8 | Data-in bus from memory |
| dout_o | output | 8 | Data-out bus, ALU result when route bit is 0 |
| addr_o | output | 16 | Address bus, gated AR |
| ir_o | output | 8 | Gated instruction register to the controller |
| carry_o | output | 1 | Carry out of the add function |

## Verification
The assertions assume that `ctl_i` and `din_i` change only while the clock is low and are stable at the rising edge. They also assume the controller may set any combination of bits, including load and increment of PC together. The bench drives every new word on the falling edge and samples one nanosecond later. Register effects are sampled one nanosecond after the next rising edge. Stimulus pairs each loaded value with later words that have the load bits clear, so hold behaviour is observed at the ports.

// File: rtl/dp_pkg.sv
`timescale 1ns/1ps
package dp_pkg;
    parameter int unsigned DW   = 8;
    parameter int unsigned AW   = 16;
    parameter int unsigned OPW  = 5;
    localparam int unsigned CTLW = 10 + 1 + OPW + 1 + 1;

    typedef struct packed {
        logic            ir_in;
        logic            ir_out;
        logic            ar_in;
        logic            ar_out;
        logic            d1_in;
        logic            d1_out;
        logic            d2_in;
        logic            d2_out;
        logic            pc_in;
        logic            pc_out;
        logic            opsel;
        logic [OPW-1:0]  alu_op;
        logic            route;
        logic            pc_inc;
    } ctl_t;

    typedef struct packed {
        logic [DW-1:0] ir;
        logic [AW-1:0] ar;
        logic [DW-1:0] d1;
        logic [DW-1:0] d2;
        logic [DW-1:0] pc;
    } regs_t;

    typedef enum logic [OPW-1:0] {
        OP_ADD   = 5'b00000,
        OP_SUB   = 5'b00001,
        OP_INCA  = 5'b00010,
        OP_DECA  = 5'b00011,
        OP_PASSA = 5'b00100,
        OP_PASSB = 5'b00101,
        OP_AND   = 5'b10000,
        OP_OR    = 5'b10001,
        OP_XOR   = 5'b10010,
        OP_NOTA  = 5'b10011
    } alu_op_e;
endpackage

// File: rtl/dp_mux2.sv
`timescale 1ns/1ps
module dp_mux2 #(
    parameter int unsigned W = 8
) (
    input  logic         sel,
    input  logic [W-1:0] leg_a,
    input  logic [W-1:0] leg_b,
    output logic [W-1:0] y
);
    always_comb begin
        y = sel ? leg_b : leg_a;
    end
endmodule

// File: rtl/dp_alu.sv
`timescale 1ns/1ps
module dp_alu
    import dp_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           co
);
    logic [W:0] sum_w;

    always_comb begin
        sum_w = {1'b0, a} + {1'b0, b};
        y     = '0;
        co    = 1'b0;
        case (op)
            OP_ADD:   begin y = sum_w[W-1:0]; co = sum_w[W]; end
            OP_SUB:   y = a - b;
            OP_INCA:  y = a + W'(1);
            OP_DECA:  y = a - W'(1);
            OP_PASSA: y = a;
            OP_PASSB: y = b;
            OP_AND:   y = a & b;
            OP_OR:    y = a | b;
            OP_XOR:   y = a ^ b;
            OP_NOTA:  y = ~a;
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/dp_regfile.sv
`timescale 1ns/1ps
module dp_regfile
    import dp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          c,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] alu_y,
    output regs_t         regs_q
);
    regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (c.ir_in) regs_d.ir = din;
        if (c.ar_in) regs_d.ar = c.route ? AW'(alu_y) : AW'(din);
        if (c.d1_in) regs_d.d1 = din;
        if (c.d2_in) regs_d.d2 = din;
        if (c.pc_in)       regs_d.pc = din;
        else if (c.pc_inc) regs_d.pc = regs_q.pc + DW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end
endmodule

// File: rtl/dp_core.sv
`timescale 1ns/1ps
module dp_core
    import dp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CTLW-1:0]       ctl_i,
    input  logic [DW-1:0]         din_i,
    output logic [DW-1:0]         dout_o,
    output logic [AW-1:0]         addr_o,
    output logic [DW-1:0]         ir_o,
    output logic                  carry_o
);
    ctl_t          c;
    regs_t         regs_q;
    logic [DW-1:0] d1_g, d2_g, pc_g, opnd_b, alu_y;

    assign c = ctl_t'(ctl_i);

    always_comb begin
        d1_g = c.d1_out ? regs_q.d1 : '0;
        d2_g = c.d2_out ? regs_q.d2 : '0;
        pc_g = c.pc_out ? regs_q.pc : '0;
    end

    dp_mux2 #(.W(DW)) u_opmux (
        .sel   (c.opsel),
        .leg_a (d1_g),
        .leg_b (pc_g),
        .y     (opnd_b)
    );

    dp_alu #(.W(DW)) u_alu (
        .op (c.alu_op),
        .a  (d2_g),
        .b  (opnd_b),
        .y  (alu_y),
        .co (carry_o)
    );

    dp_regfile u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .c      (c),
        .din    (din_i),
        .alu_y  (alu_y),
        .regs_q (regs_q)
    );

    always_comb begin
        dout_o = c.route  ? '0 : alu_y;
        addr_o = c.ar_out ? regs_q.ar : '0;
        ir_o   = c.ir_out ? regs_q.ir : '0;
    end
endmodule

// File: rtl/dp_core_chk.sv
`timescale 1ns/1ps
module dp_core_chk
    import dp_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [CTLW-1:0] ctl_i,
    input regs_t           regs_q,
    input logic [DW-1:0]   alu_y,
    input logic [DW-1:0]   dout_o,
    input logic [DW-1:0]   ir_o,
    input logic            carry_o
);
    ctl_t c;
    assign c = ctl_t'(ctl_i);

    // R6
    route_blocks_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c.route |-> dout_o == '0);

    // R11
    ir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !c.ir_out |-> ir_o == '0);

    // R3
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !c.ir_in |=> $stable(regs_q.ir));

    // R10
    pc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c.pc_inc && !c.pc_in) |=> regs_q.pc == DW'($past(regs_q.pc) + DW'(1)));

    // R8
    carry_only_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |-> c.alu_op == 5'b00000);

    // R6
    ar_from_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c.ar_in && c.route) |=> regs_q.ar == AW'($past(alu_y)));
endmodule

bind dp_core dp_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_i   (ctl_i),
    .regs_q  (regs_q),
    .alu_y   (alu_y),
    .dout_o  (dout_o),
    .ir_o    (ir_o),
    .carry_o (carry_o)
);

// File: tb/test_dp_core.sv
`timescale 1ns/1ps
module test_dp_core;
    localparam logic [17:0] IR_IN  = 18'h20000, IR_OUT = 18'h10000;
    localparam logic [17:0] AR_IN  = 18'h08000, AR_OUT = 18'h04000;
    localparam logic [17:0] D1_IN  = 18'h02000, D1_OUT = 18'h01000;
    localparam logic [17:0] D2_IN  = 18'h00800, D2_OUT = 18'h00400;
    localparam logic [17:0] PC_IN  = 18'h00200, PC_OUT = 18'h00100;
    localparam logic [17:0] OPSEL  = 18'h00080, ROUTE  = 18'h00002;
    localparam logic [17:0] PC_INC = 18'h00001;
    localparam logic [17:0] T1W    = 18'b00_11_00_00_01_1_00101_1_0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] ctl = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout, ir;
    logic [15:0] addr;
    logic        co;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    dp_core i_dp_core (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .din_i(din),
        .dout_o(dout), .addr_o(addr), .ir_o(ir), .carry_o(co)
    );

    function automatic logic [17:0] op(input logic [4:0] code);
        return {11'd0, code, 2'd0};
    endfunction

    task automatic drive(input logic [17:0] w, input logic [7:0] d);
        @(negedge clk);
        ctl = w;
        din = d;
        #1;
    endtask

    task automatic edge1();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        drive(IR_OUT | AR_OUT, 8'h00);
        chk("R1 addr", addr, 16'h0000);
        chk("R1 ir", {8'h0, ir}, 16'h0000);
        chk("R1 dout", {8'h0, dout}, 16'h0000);
    endtask

    task automatic t_operands();
        drive(D1_IN, 8'h3C); edge1();
        drive(D2_IN, 8'h05); edge1();
        drive(D1_OUT | op(5'b00101), 8'h00);
        chk("R3 R5 D1 on B", {8'h0, dout}, 16'h003C);
        drive(D2_OUT | op(5'b00100), 8'h00);
        chk("R5 D2 on A", {8'h0, dout}, 16'h0005);
        drive(op(5'b00101), 8'h00);
        chk("R4 D1 drive off", {8'h0, dout}, 16'h0000);
    endtask

    task automatic t_alu();
        logic [17:0] both;
        both = D1_OUT | D2_OUT;
        drive(both | op(5'b00000), 8'h00);
        chk("R7 add", {8'h0, dout}, 16'h0041);
        chk("R8 no carry", {15'h0, co}, 16'h0000);
        drive(D2_IN, 8'hF0); edge1();
        drive(both | op(5'b00000), 8'h00);
        chk("R7 add wrap", {8'h0, dout}, 16'h002C);
        chk("R8 carry", {15'h0, co}, 16'h0001);
        drive(both | op(5'b00001), 8'h00);
        chk("R7 sub", {8'h0, dout}, 16'h00B4);
        chk("R8 sub no carry", {15'h0, co}, 16'h0000);
        drive(both | op(5'b00010), 8'h00); chk("R7 inc", {8'h0, dout}, 16'h00F1);
        drive(both | op(5'b00011), 8'h00); chk("R7 dec", {8'h0, dout}, 16'h00EF);
        drive(both | op(5'b10000), 8'h00); chk("R7 and", {8'h0, dout}, 16'h0030);
        drive(both | op(5'b10001), 8'h00); chk("R7 or",  {8'h0, dout}, 16'h00FC);
        drive(both | op(5'b10010), 8'h00); chk("R7 xor", {8'h0, dout}, 16'h00CC);
        drive(both | op(5'b10011), 8'h00); chk("R7 not", {8'h0, dout}, 16'h000F);
        drive(both | op(5'b01111), 8'h00); chk("R7 unused 01111", {8'h0, dout}, 16'h0000);
        drive(both | op(5'b11111), 8'h00); chk("R7 unused 11111", {8'h0, dout}, 16'h0000);
    endtask

    task automatic t_pc();
        drive(PC_IN, 8'h10); edge1();
        drive(T1W, 8'h00);
        chk("R6 route hides dout", {8'h0, dout}, 16'h0000);
        edge1();
        chk("R2 R9 fetch word", addr, 16'h0010);
        drive(PC_INC, 8'h00); edge1(); edge1();
        drive(T1W, 8'h00); edge1();
        chk("R10 two increments", addr, 16'h0012);
        drive(PC_OUT | OPSEL | op(5'b00101), 8'h00);
        chk("R5 PC on B", {8'h0, dout}, 16'h0012);
        drive(OPSEL | op(5'b00101), 8'h00);
        chk("R4 PC drive off", {8'h0, dout}, 16'h0000);
        drive(PC_IN, 8'hFF); edge1();
        drive(PC_INC, 8'h00); edge1();
        drive(T1W, 8'h00); edge1();
        chk("R10 wrap", addr, 16'h0000);
        drive(PC_IN | PC_INC, 8'h40); edge1();
        drive(T1W, 8'h00); edge1();
        chk("R10 load wins", addr, 16'h0040);
    endtask

    task automatic t_ar();
        drive(AR_IN | AR_OUT, 8'h9B); edge1();
        chk("R3 AR from din", addr, 16'h009B);
        drive(AR_OUT, 8'h55); edge1();
        chk("R3 AR hold", addr, 16'h009B);
        drive(18'h0, 8'h00);
        chk("R11 AR drive off", addr, 16'h0000);
    endtask

    task automatic t_ir();
        drive(IR_IN | IR_OUT, 8'hA7); edge1();
        chk("R3 IR load", {8'h0, ir}, 16'h00A7);
        drive(IR_OUT, 8'h11); edge1();
        chk("R3 IR hold", {8'h0, ir}, 16'h00A7);
        drive(18'h0, 8'h00);
        chk("R11 IR drive off", {8'h0, ir}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_operands();
        t_alu();
        t_pc();
        t_ar();
        t_ir();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule